// File: doc/BRIEF.md
# Banked Memory Depth and Width Expander

This block presents one large word-addressed memory built from a grid of identical small RAM banks. The grid has rows and columns. Depth grows by adding rows: the top address bits pass through a small decoder, and each decoder output is the chip select of one row. Width grows by adding columns: the banks in a row share the address, the chip select and the write control, and each bank stores one byte lane of the wide word. At the default parameters there are four rows of two 16x8 banks, which give a 64 x 16 logical memory.

The row decoder runs only while the memory enable is high, so no bank is selected while the memory is idle. A write stores the whole wide word in the selected row in a single cycle. A read captures the addressed word in the selected row's banks. A two-state read-return sequencer remembers which row was read and steers that row's data to the output in the next cycle.

Sequencer states: `RSEQ_IDLE` drives zero on the output, and `RSEQ_RETURN` drives the data of the row read in the previous cycle. The state moves to `RSEQ_RETURN` after any cycle with the memory enable high and write control low. It moves to `RSEQ_IDLE` after any other cycle, either from `RSEQ_RETURN` or by staying in `RSEQ_IDLE`.

Top module: `mem_exp_top`

## Requirements
- R1: The upper address bits `addr[5:4]` select the row. Value 00 selects row 0, 01 selects row 1, 10 selects row 2 and 11 selects row 3. Each row covers 16 consecutive words, so a write to one row is never seen at any address of another row.
- R2: The lower address bits `addr[3:0]` go unchanged to every bank. A write to one word does not change any other word in the same row.
- R3: While `mem_en` is low, no row is selected. A cycle with `mem_en` low and `wr_en` high changes no stored word.
- R4: Byte lane 0 stores `wdata[7:0]` and returns it on `rdata[7:0]`. Byte lane 1 stores `wdata[15:8]` and returns it on `rdata[15:8]`. Both lanes are written in the same cycle from the same address.
- R5: A read is a cycle with `mem_en` high and `wr_en` low. After the next rising edge, `rdata` holds the word stored at `addr`, including a word written in the cycle just before.
- R6: After a rising edge that ends a cycle with `mem_en` low or `wr_en` high, `rdata` is zero.
- R7: After reset, `rdata` is zero and every stored word is zero.
- R8: A read does not change any stored word, so repeated reads of one address return the same value.
- R9: At most one row is selected in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_en | input | 1 | Memory enable; gates the row decoder |
| wr_en | input | 1 | 1 = write, 0 = read, when `mem_en` is high |
| addr | input | 6 | Word address: row in [5:4], in-bank offset in [3:0] |
| wdata | input | 16 | Write data, two byte lanes |
| rdata | output | 16 | Read data, one cycle after a read, else zero |

## Verification
The assertions take the control inputs to be 0 or 1 and never unknown once reset is released. The row-select checks also take the address to be defined in every cycle where `mem_en` is high. The stimulus drives every input to a known value from time zero and changes inputs only at falling edges, well away from the sampling edge. When a cycle leaves the address unused, the stimulus still holds a legal value on it.

// File: rtl/mem_exp_pkg.sv
package mem_exp_pkg;

    // Read-return sequencer states
    typedef enum logic [0:0] {
        RSEQ_IDLE   = 1'b0,
        RSEQ_RETURN = 1'b1
    } rseq_state_t;

endpackage

// File: rtl/mem_exp_decoder.sv
module mem_exp_decoder #(
    parameter int NUM_OUT = 4,
    parameter int SEL_W   = $clog2(NUM_OUT)
) (
    input  logic               en,
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_OUT-1:0] onehot
);

    // Gated binary-to-one-hot: no output active while disabled
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign onehot[i] = en && (sel == SEL_W'(i));
    end

endmodule

// File: rtl/mem_exp_bank.sv
module mem_exp_bank #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          we,
    input  logic [AW-1:0] a,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Synchronous single-port behavioural RAM, registered read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
            q <= '0;
        end else if (cs) begin
            if (we) begin
                cells[a] <= d;
            end else begin
                q <= cells[a];
            end
        end
    end

endmodule

// File: rtl/mem_exp_seq.sv
module mem_exp_seq
    import mem_exp_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_en,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] row_sel,
    output logic             out_live,
    output logic [SEL_W-1:0] out_row
);

    rseq_state_t state_q, state_d;
    logic [SEL_W-1:0] row_q;

    always_comb begin
        state_d = (mem_en && !wr_en) ? RSEQ_RETURN : RSEQ_IDLE;
    end

    // State register with captured row of the pending read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSEQ_IDLE;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == RSEQ_RETURN) begin
                row_q <= row_sel;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        out_live = 1'b0;
        out_row  = row_q;
        unique case (state_q)
            RSEQ_IDLE:   out_live = 1'b0;
            RSEQ_RETURN: out_live = 1'b1;
            default:     out_live = 1'b0;
        endcase
    end

endmodule

// File: rtl/mem_exp_top.sv
module mem_exp_top #(
    parameter int BANK_AW   = 4,
    parameter int NUM_ROWS  = 4,
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 2,
    parameter int SEL_W     = $clog2(NUM_ROWS),
    parameter int ADDR_W    = SEL_W + BANK_AW,
    parameter int DATA_W    = LANE_W * NUM_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [SEL_W-1:0]                 row_sel;
    logic [BANK_AW-1:0]               bank_addr;
    logic [NUM_ROWS-1:0]              bank_cs;
    logic [NUM_ROWS-1:0][DATA_W-1:0]  row_rd;
    logic                             out_live;
    logic [SEL_W-1:0]                 out_row;

    assign row_sel   = addr[ADDR_W-1 -: SEL_W];
    assign bank_addr = addr[BANK_AW-1:0];

    mem_exp_decoder #(
        .NUM_OUT (NUM_ROWS),
        .SEL_W   (SEL_W)
    ) u_dec (
        .en     (mem_en),
        .sel    (row_sel),
        .onehot (bank_cs)
    );

    // Grid: rows extend depth, lanes extend width
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
            mem_exp_bank #(
                .AW (BANK_AW),
                .DW (LANE_W)
            ) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .cs    (bank_cs[r]),
                .we    (wr_en),
                .a     (bank_addr),
                .d     (wdata[l*LANE_W +: LANE_W]),
                .q     (row_rd[r][l*LANE_W +: LANE_W])
            );
        end
    end

    mem_exp_seq #(
        .SEL_W (SEL_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_en   (mem_en),
        .wr_en    (wr_en),
        .row_sel  (row_sel),
        .out_live (out_live),
        .out_row  (out_row)
    );

    assign rdata = out_live ? row_rd[out_row] : '0;

endmodule

// File: rtl/mem_exp_chk.sv
module mem_exp_chk #(
    parameter int NUM_ROWS = 4,
    parameter int SEL_W    = 2,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_ROWS-1:0] bank_cs
);

    // R3: disabled memory selects no row
    a_r3_no_sel_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> (bank_cs == '0));

    // R9: never more than one row active
    a_r9_single_row: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_cs));

    // R1: enabled access selects the row named by the top address bits
    a_r1_row_decode: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (bank_cs == (NUM_ROWS'(1) << addr[ADDR_W-1 -: SEL_W])));

    // R6: output zero after a non-read cycle
    a_r6_zero_after_nonread: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_en && !wr_en) |=> (rdata == '0));

    // R1: an enabled access always drives exactly one row
    a_r1_one_row_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> ($countones(bank_cs) == 1));

endmodule

bind mem_exp_top mem_exp_chk #(
    .NUM_ROWS (NUM_ROWS),
    .SEL_W    (SEL_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_en  (mem_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .rdata   (rdata),
    .bank_cs (bank_cs)
);

// File: tb/mem_exp_top_bench.sv
`timescale 1ns/1ps
module mem_exp_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] ref_mem [64];
    logic [15:0] exp_rd = '0;
    string       cur_tag = "R7";

    always #4 clk = ~clk;

    mem_exp_top u_mem_exp_top (
        .clk    (clk),
        .rst_n  (rst_n),
        .mem_en (mem_en),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic cyc(input string tag, input logic en, input logic we,
                       input logic [5:0] a, input logic [15:0] d);
        mem_en  = en;
        wr_en   = we;
        addr    = a;
        wdata   = d;
        cur_tag = tag;
        @(posedge clk);
        #1;
        if (en && we) begin
            ref_mem[a] = d;
            exp_rd = '0;
        end else if (en) begin
            exp_rd = ref_mem[a];
        end else begin
            exp_rd = '0;
        end
        @(negedge clk);
        check(tag, rdata, exp_rd);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        check("R7", rdata, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", rdata, 16'h0000);

        // R7: all words zero after reset
        for (int a = 0; a < 64; a++) cyc("R7", 1'b1, 1'b0, 6'(a), 16'h0);

        // R1/R2: distinct values at first and last word of every row
        for (int r = 0; r < 4; r++) begin
            cyc("R1", 1'b1, 1'b1, 6'(r * 16),      16'hA100 + 16'(r));
            cyc("R1", 1'b1, 1'b1, 6'(r * 16 + 15), 16'h5E00 + 16'(r * 17));
        end
        // R1/R2: full sweep shows no aliasing across rows or offsets
        for (int a = 0; a < 64; a++) cyc("R2", 1'b1, 1'b0, 6'(a), 16'h0);

        // R6: output zero after writes and idle cycles
        cyc("R6", 1'b1, 1'b1, 6'd5, 16'h1234);
        cyc("R6", 1'b0, 1'b0, 6'd5, 16'h0);
        cyc("R6", 1'b0, 1'b1, 6'd5, 16'h0);

        // R3: disabled write does not land in any row
        for (int r = 0; r < 4; r++) cyc("R3", 1'b0, 1'b1, 6'(r * 16), 16'hDEAD);
        cyc("R3", 1'b0, 1'b1, 6'd5, 16'hBEEF);
        for (int r = 0; r < 4; r++) cyc("R3", 1'b1, 1'b0, 6'(r * 16), 16'h0);
        cyc("R3", 1'b1, 1'b0, 6'd5, 16'h0);

        // R4: byte lanes stored and returned independently
        cyc("R4", 1'b1, 1'b1, 6'd20, 16'h00FF);
        cyc("R4", 1'b1, 1'b1, 6'd21, 16'hFF00);
        cyc("R4", 1'b1, 1'b1, 6'd22, 16'hC33C);
        cyc("R4", 1'b1, 1'b0, 6'd20, 16'h0);
        cyc("R4", 1'b1, 1'b0, 6'd21, 16'h0);
        cyc("R4", 1'b1, 1'b0, 6'd22, 16'h0);

        // R5: read right after write, back-to-back across rows
        cyc("R5", 1'b1, 1'b1, 6'd47, 16'h7A5B);
        cyc("R5", 1'b1, 1'b0, 6'd47, 16'h0);
        cyc("R5", 1'b1, 1'b0, 6'd63, 16'h0);
        cyc("R5", 1'b1, 1'b0, 6'd0,  16'h0);
        cyc("R5", 1'b1, 1'b0, 6'd32, 16'h0);

        // R8: repeated reads return the same word
        for (int k = 0; k < 3; k++) cyc("R8", 1'b1, 1'b0, 6'd47, 16'h0);

        // R1: pattern over every address, then sweep back
        for (int a = 0; a < 64; a++) cyc("R1", 1'b1, 1'b1, 6'(a), 16'(a * 16'h0101) ^ 16'h9C00);
        for (int a = 63; a >= 0; a--) cyc("R1", 1'b1, 1'b0, 6'(a), 16'h0);
        cyc("R6", 1'b0, 1'b0, 6'd0, 16'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule